// File: doc/BRIEF.md
# Sticky Interrupt Collector with Global Mask

This block gathers single-cycle event pulses from a set of sources into sticky status flags. Each flag stays set until software writes a 1 to its position. A single global mask, set at reset, gates the interrupt request. Events that arrive while the mask is set are still recorded. They raise the request as soon as software clears the mask. An optional per-source mask keeps selected flags from raising the request, but those flags still record their events.

The interrupt output is meant for an active-low, open-drain pad. The block drives only an output-enable. When the enable is 1 the pad pulls the line low. When it is 0 the pad floats, and it is never driven high.

Software reaches the block through a small register port with a valid/ready request channel and a valid/ready read-response channel. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. A read then returns exactly one response. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen high. No new request is accepted while a response is waiting. Writes produce no response.

Top module: `irq_collect`

## Requirements
- R1: After reset the global mask reads 1, every status flag and every per-source mask bit reads 0, and `irq_oe` is 0.
- R2: A 1 on bit i of `evt` sets status flag i at the next clock edge. The flag stays 1 until it is cleared by R3.
- R3: A write to address 0 clears each status flag whose data bit is 1 and leaves the other flags unchanged. Writing 0 has no effect, and no write can set a flag.
- R4: If an event for flag i arrives in the same cycle as a write that clears flag i, the flag stays 1.
- R5: `irq_oe` is 1 exactly when the global mask is 0 and at least one status flag is 1 whose per-source mask bit is 0. It follows the register state in the same cycle.
- R6: While the global mask is 1, events still set their flags but `irq_oe` stays 0.
- R7: When a write to address 1 clears bit 0 while a flag is pending, `irq_oe` is 1 in the cycle after the write is accepted.
- R8: When a write to address 1 sets bit 0, `irq_oe` is 0 in the cycle after the write is accepted, even if flags are pending.
- R9: At address 1, bit 0 is the global mask and is read/write. Its other bits read 0. Status bits above the number of sources read 0.
- R10: At address 2, bit i is the per-source mask for source i and is read/write. A masked flag still records its events.
- R11: A read returns the register value as it was in the cycle the request was accepted. `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is high. `req_ready` is 0 while a response is pending.
- R12: Reads of address 3 return 0. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NSRC | Single-cycle event pulses, one per source |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | DW | Read response data |
| irq_oe | output | 1 | Pull the active-low interrupt line low when 1 |

## Verification
The bench builds the block with six sources, an 8-bit data path and per-source masking enabled. With six sources, the two top status bits have no flag behind them, so the checks can show that they read 0 and that writing 1 to them does nothing. With per-source masking enabled, the bench can reach the case where a pending flag is held back from the request while other flags still raise it. The response channel is throttled in a repeating pattern, so reads meet back-pressure and the held-response rules get exercised.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADR_STATUS = 0;
  localparam int unsigned ADR_CTRL   = 1;
  localparam int unsigned ADR_SMASK  = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_SMASK
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] status
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
      end else if (evt[i]) begin
        status[i] <= 1'b1;
      end else if (clr[i]) begin
        status[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int unsigned NSRC        = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter bit          SRC_MASK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  input  logic [NSRC-1:0]   status,
  output logic [NSRC-1:0]   clr,
  output logic              gmask,
  output logic [NSRC-1:0]   smask
);
  reg_sel_e        sel;
  logic            accept;
  logic            wr_en;
  logic            rd_en;
  logic [DW-1:0]   rd_mux;
  logic            rsp_valid_q;
  logic [DW-1:0]   rsp_data_q;

  always_comb begin
    if (req_addr == ADDR_W'(ADR_STATUS))      sel = SEL_STATUS;
    else if (req_addr == ADDR_W'(ADR_CTRL))   sel = SEL_CTRL;
    else if (req_addr == ADDR_W'(ADR_SMASK))  sel = SEL_SMASK;
    else                                      sel = SEL_NONE;
  end

  assign req_ready = !rsp_valid_q;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;
  assign rd_en     = accept && !req_write;

  assign clr = (wr_en && sel == SEL_STATUS) ? req_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask <= 1'b1;
    end else if (wr_en && sel == SEL_CTRL) begin
      gmask <= req_wdata[0];
    end
  end

  if (SRC_MASK_EN) begin : g_smask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smask <= '0;
      end else if (wr_en && sel == SEL_SMASK) begin
        smask <= req_wdata[NSRC-1:0];
      end
    end
  end else begin : g_no_smask
    assign smask = '0;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STATUS: rd_mux[NSRC-1:0] = status;
      SEL_CTRL:   rd_mux[0]        = gmask;
      SEL_SMASK:  rd_mux[NSRC-1:0] = smask;
      default:    rd_mux           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_en) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned NSRC = 8
) (
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] smask,
  input  logic            gmask,
  output logic            irq_oe
);
  logic [NSRC-1:0] live;

  assign live   = status & ~smask;
  assign irq_oe = (|live) && !gmask;
endmodule

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int unsigned NSRC        = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter bit          SRC_MASK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              irq_oe
);
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] smask_q;
  logic            gmask_q;

  irq_status_bank #(.NSRC(NSRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .clr    (clr_bits),
    .status (status_q)
  );

  irq_regif #(
    .NSRC(NSRC), .DW(DW), .ADDR_W(ADDR_W), .SRC_MASK_EN(SRC_MASK_EN)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .status    (status_q),
    .clr       (clr_bits),
    .gmask     (gmask_q),
    .smask     (smask_q)
  );

  irq_pin_drv #(.NSRC(NSRC)) u_pin (
    .status (status_q),
    .smask  (smask_q),
    .gmask  (gmask_q),
    .irq_oe (irq_oe)
  );
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] clr_bits,
  input logic            gmask_q,
  input logic            irq_oe,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [DW-1:0]   rsp_data
);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_bits)) == $past(status_q & ~clr_bits)));

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt)) == $past(evt)));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |-> !irq_oe);

  // R5
  request_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (status_q != '0));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind irq_collect irq_collect_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt       (evt),
  .status_q  (status_q),
  .clr_bits  (clr_bits),
  .gmask_q   (gmask_q),
  .irq_oe    (irq_oe),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/sim_irq_collect.sv
`timescale 1ns/1ps
module sim_irq_collect;
  localparam int unsigned NSRC = 6;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] evt = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b0;
  logic [DW-1:0]   rsp_data;
  logic            irq_oe;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          held = 1'b0;
  logic [DW-1:0] held_data = '0;

  always #4 clk = ~clk;

  irq_collect #(.NSRC(NSRC), .DW(DW), .ADDR_W(AW), .SRC_MASK_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // response throttle: ready low one cycle in three
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 rsp_ready <= (cyc % 3 != 0);
  end

  // monitor: pop expected reads, check hold under back-pressure
  always @(negedge clk) begin
    if (held) begin
      check("R11 hold", {7'd0, rsp_valid}, 8'd1);
      check("R11 stable", rsp_data, held_data);
    end
    held <= 1'b0;
    if (rsp_valid) begin
      check("R11 ready low", {7'd0, req_ready}, 8'd0);
      if (rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R11 extra response", rsp_data, 8'hxx);
        end else begin
          check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
        end
      end else begin
        held <= 1'b1;
        held_data <= rsp_data;
      end
    end
  end

  task automatic bus_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_op(1'b1, a, d);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_op(1'b0, a, '0);
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_oe(input logic e, input string tag);
    check(tag, {7'd0, irq_oe}, {7'd0, e});
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_oe(1'b0, "R1 oe");
    rd_reg(1, 8'h01, "R1 ctrl");
    rd_reg(0, 8'h00, "R1 status");
    rd_reg(2, 8'h00, "R1 smask");
    // R6 events latch while masked
    pulse(6'b000101);
    chk_oe(1'b0, "R6 oe masked");
    rd_reg(0, 8'h05, "R6 status latched");
    drain();
    // R7 unmask with pending
    wr_reg(1, 8'h00);
    chk_oe(1'b1, "R7 oe after unmask");
    // R3 zero write no effect, partial clear
    wr_reg(0, 8'h00);
    rd_reg(0, 8'h05, "R3 zero write");
    wr_reg(0, 8'h01);
    rd_reg(0, 8'h04, "R3 partial clear");
    drain();
    chk_oe(1'b1, "R5 oe one pending");
    wr_reg(0, 8'h04);
    chk_oe(1'b0, "R5 oe all cleared");
    // R2 event while unmasked
    pulse(6'b000010);
    chk_oe(1'b1, "R2 R5 oe on event");
    repeat (4) @(negedge clk);
    rd_reg(0, 8'h02, "R2 sticky");
    drain();
    // R8 mask forces release
    wr_reg(1, 8'h01);
    chk_oe(1'b0, "R8 oe forced off");
    rd_reg(0, 8'h02, "R8 status kept");
    drain();
    wr_reg(1, 8'h00);
    chk_oe(1'b1, "R7 oe again");
    wr_reg(0, 8'h02);
    chk_oe(1'b0, "R5 oe cleared");
    // R4 event and clear in the same cycle
    pulse(6'b010000);
    drain();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 0; req_wdata = 8'h18;
    evt = 6'b001000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; evt = '0;
    rd_reg(0, 8'h08, "R4 event wins");
    drain();
    // R10 per-source mask
    wr_reg(2, 8'h08);
    chk_oe(1'b0, "R10 masked source");
    rd_reg(2, 8'h08, "R10 smask readback");
    pulse(6'b100000);
    chk_oe(1'b1, "R10 unmasked source");
    rd_reg(0, 8'h28, "R10 masked still latches");
    drain();
    wr_reg(0, 8'h20);
    chk_oe(1'b0, "R10 only masked left");
    wr_reg(2, 8'h00);
    chk_oe(1'b1, "R10 mask removed");
    wr_reg(0, 8'h08);
    chk_oe(1'b0, "R3 all clear");
    // R9 control width and unused status bits
    wr_reg(1, 8'hFF);
    rd_reg(1, 8'h01, "R9 ctrl upper zero");
    wr_reg(1, 8'hFE);
    rd_reg(1, 8'h00, "R9 ctrl bit0 rw");
    pulse(6'b111111);
    wr_reg(0, 8'hC0);
    rd_reg(0, 8'h3F, "R9 upper status bits");
    drain();
    wr_reg(0, 8'hFF);
    rd_reg(0, 8'h00, "R3 full clear");
    // R12 unused address
    rd_reg(3, 8'h00, "R12 read zero");
    wr_reg(3, 8'hFF);
    rd_reg(1, 8'h00, "R12 ctrl untouched");
    rd_reg(2, 8'h00, "R12 smask untouched");
    rd_reg(0, 8'h00, "R12 status untouched");
    drain();
    chk_oe(1'b0, "R12 oe idle");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule